// File: doc/BRIEF.md
# Masked Alarm Latch Register

This block captures transient condition flags from a monitoring device into a sticky status register that the host can poll or take as an interrupt. Each raw flag follows its condition and clears by itself. A 16-bit enable mask decides which raw flags are captured at all. An enabled flag that is high at a clock edge sets its status bit. That bit then stays set until the host writes a one to it.

The mask starts from a default value. A separate default-mask register holds this value, and the host can change it only while a configuration-update input is high. When the device leaves configuration-update mode, the mask is reloaded from that default. A registered, active-high alert output tells the host that at least one status bit is latched.

A small register port with a 2-bit address gives access to the raw flags, the latched status, the mask and the default mask. Writes use single-cycle strobes, and read data is combinational. In the status register, bit 7 marks a completed measurement scan, and bits 15 and 14 summarise safety and protection events.

Top module: `alarm_latch_top`

## Requirements
- R1: After reset the status register reads 0x0000, the alert output is low, and both the mask (address 2) and the default mask (address 3) read 0xF882.
- R2: Address 0 returns the raw input flags combinationally. A write to address 0 changes no register.
- R3: A raw flag sets its status bit at a clock edge only if the matching mask bit is 1 at that edge. Raw flags whose mask bit is 0 are never captured.
- R4: A latched status bit stays set after its raw flag returns to 0, until the host clears it.
- R5: Writing to address 1 clears exactly the status bits written as 1 and leaves every other bit unchanged. Writing 0x0080 clears only bit 7, and writing 0xF800 clears bits 15 down to 11.
- R6: If a clear and a new capture of the same bit fall in the same cycle, the bit stays set.
- R7: Clearing a mask bit does not clear a status bit that is already latched.
- R8: A write to address 2 replaces the mask from the next cycle on, and address 2 reads back exactly the mask in use.
- R9: Address 3 accepts writes only while the configuration-update input is high. In the cycle after that input falls, the mask is loaded from the default mask, and this reload takes priority over a mask write in the same cycle.
- R10: The alert output goes high one clock after the first status bit is latched, and goes low one clock after the last one is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 16 | Transient raw condition flags |
| cfg_mode_i | input | 1 | High while in configuration-update mode |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register select: 0 raw, 1 status, 2 mask, 3 default mask |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| alert_o | output | 1 | Registered flag, high while any status bit is latched |

## Verification
The hardest case to reach from the ports is a cycle in which several events collide on the same bits. One example is a write-one-to-clear landing on the edge where a new enabled flag arrives. Another is leaving configuration mode in the same cycle as a host write to the mask. The stimulus table drives raw flags and clear writes on the same edge and then reads the status back. The directed tests drop the configuration input in the same cycle as a mask write and compare the mask against the default value.

// File: rtl/alarm_latch_pkg.sv
package alarm_latch_pkg;
    parameter int ALARM_W = 16;
    parameter int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_DFLT   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/alarm_mask_ctl.sv
module alarm_mask_ctl #(
    parameter int          W          = 16,
    parameter logic [W-1:0] RESET_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cfg_mode_i,
    input  logic         mask_we_i,
    input  logic         dflt_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] dflt_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] dflt;
        logic         cfg;
    } mask_state_t;

    mask_state_t st_d, st_q;
    logic        leave_cfg;

    always_comb begin
        st_d      = st_q;
        st_d.cfg  = cfg_mode_i;
        leave_cfg = st_q.cfg && !cfg_mode_i;
        if (dflt_we_i && cfg_mode_i) begin
            st_d.dflt = wdata_i;
        end
        if (leave_cfg) begin
            st_d.mask = st_q.dflt;
        end else if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= RESET_MASK;
            st_q.dflt <= RESET_MASK;
            st_q.cfg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign dflt_o = st_q.dflt;
endmodule

// File: rtl/alarm_status_latch.sv
module alarm_status_latch #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] status;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [W-1:0] capture;

    always_comb begin
        capture     = raw_i & mask_i;
        st_d        = st_q;
        // clear first, then capture, so a capture overrides a clear of the same bit
        st_d.status = (st_q.status & ~clr_i) | capture;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
endmodule

// File: rtl/alarm_alert_reg.sv
module alarm_alert_reg #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] status_i,
    output logic         alert_o
);
    typedef struct packed {
        logic alert;
    } alert_state_t;

    alert_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.alert = |status_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alert_o = st_q.alert;
endmodule

// File: rtl/alarm_latch_top.sv
module alarm_latch_top
    import alarm_latch_pkg::*;
#(
    parameter logic [ALARM_W-1:0] RESET_MASK = 16'hF882
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ALARM_W-1:0] raw_i,
    input  logic               cfg_mode_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [ALARM_W-1:0] wdata_i,
    output logic [ALARM_W-1:0] rdata_o,
    output logic               alert_o
);
    localparam int W = ALARM_W;

    reg_sel_e     sel;
    logic         mask_we, dflt_we;
    logic [W-1:0] clr_bits;
    logic [W-1:0] mask_w, dflt_w, status_w;

    always_comb begin
        sel      = reg_sel_e'(addr_i);
        mask_we  = wr_en_i && (sel == SEL_MASK);
        dflt_we  = wr_en_i && (sel == SEL_DFLT);
        clr_bits = (wr_en_i && (sel == SEL_STATUS)) ? wdata_i : '0;
    end

    alarm_mask_ctl #(.W(W), .RESET_MASK(RESET_MASK)) u_mask (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_mode_i(cfg_mode_i),
        .mask_we_i (mask_we),
        .dflt_we_i (dflt_we),
        .wdata_i   (wdata_i),
        .mask_o    (mask_w),
        .dflt_o    (dflt_w)
    );

    alarm_status_latch #(.W(W)) u_status (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (raw_i),
        .mask_i  (mask_w),
        .clr_i   (clr_bits),
        .status_o(status_w)
    );

    alarm_alert_reg #(.W(W)) u_alert (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .status_i(status_w),
        .alert_o (alert_o)
    );

    always_comb begin
        unique case (sel)
            SEL_RAW:    rdata_o = raw_i;
            SEL_STATUS: rdata_o = status_w;
            SEL_MASK:   rdata_o = mask_w;
            SEL_DFLT:   rdata_o = dflt_w;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/alarm_latch_chk.sv
module alarm_latch_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] raw_i,
    input logic         cfg_mode_i,
    input logic         wr_en_i,
    input logic [1:0]   addr_i,
    input logic [W-1:0] wdata_i,
    input logic [W-1:0] mask_w,
    input logic [W-1:0] dflt_w,
    input logic [W-1:0] status_w,
    input logic         alert_o
);
    logic [W-1:0] enabled;
    logic [W-1:0] host_clr;

    assign enabled  = raw_i & mask_w;
    assign host_clr = (wr_en_i && addr_i == 2'd1) ? wdata_i : '0;

    assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> ((status_w & $past(enabled)) == $past(enabled)));

    assert_no_stray_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> ((status_w & ~$past(status_w) & ~$past(enabled)) == '0));

    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> (($past(status_w) & ~$past(host_clr) & ~status_w) == '0));

    assert_mask_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd2 && cfg_mode_i) |=> (mask_w == $past(wdata_i)));

    assert_dflt_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_mode_i |=> $stable(dflt_w));

    assert_alert_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1 |=> (alert_o == (|$past(status_w))));
endmodule

bind alarm_latch_top alarm_latch_chk #(.W(16)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_i),
    .cfg_mode_i(cfg_mode_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .mask_w    (mask_w),
    .dflt_w    (dflt_w),
    .status_w  (status_w),
    .alert_o   (alert_o)
);

// File: tb/alarm_latch_top_tb.sv
module alarm_latch_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] raw = '0;
    logic        cfg_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        alert;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    alarm_latch_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .cfg_mode_i(cfg_mode),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .alert_o(alert)
    );

    // {raw, we, addr, wdata, expected status}
    localparam int NV = 14;
    localparam logic [50:0] VEC [NV] = '{
        {16'h0001, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R3 masked-off bit
        {16'h0080, 1'b0, 2'd0, 16'h0000, 16'h0080}, // R3 scan bit
        {16'h0000, 1'b0, 2'd0, 16'h0000, 16'h0080}, // R4 sticky
        {16'hC000, 1'b0, 2'd0, 16'h0000, 16'hC080}, // R3 safety bits
        {16'h0000, 1'b1, 2'd1, 16'h0080, 16'hC000}, // R5 clear bit 7 only
        {16'h0800, 1'b1, 2'd1, 16'hF800, 16'h0800}, // R6 capture beats clear
        {16'h0000, 1'b1, 2'd2, 16'h0000, 16'h0800}, // R7 mask cleared
        {16'hFFFF, 1'b0, 2'd0, 16'h0000, 16'h0800}, // R7/R3 no capture, kept
        {16'hFFFF, 1'b1, 2'd1, 16'hFFFF, 16'h0000}, // R5 clear all
        {16'h0000, 1'b1, 2'd2, 16'h0003, 16'h0000}, // R8 new mask
        {16'h0002, 1'b0, 2'd0, 16'h0000, 16'h0002}, // R8 new mask used
        {16'h0001, 1'b1, 2'd1, 16'h0002, 16'h0001}, // R5 clear one, capture other
        {16'h0000, 1'b1, 2'd1, 16'h00FE, 16'h0001}, // R5 zeros leave bit 0
        {16'h0000, 1'b1, 2'd1, 16'h0001, 16'h0000}  // R5 final clear
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        wr_en = 1'b0;
        addr  = a;
        #0.5;
        v = rdata;
    endtask

    task automatic step(input logic [15:0] r, input logic we, input logic [1:0] a,
                        input logic [15:0] d);
        @(negedge clk);
        raw = r; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, v); check("R1 status", v, 16'h0000);
        rd(2'd2, v); check("R1 mask", v, 16'hF882);
        rd(2'd3, v); check("R1 default", v, 16'hF882);
        check("R1 alert", {15'd0, alert}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][50:35], VEC[i][34], VEC[i][33:32], VEC[i][31:16]);
            rd(2'd1, v);
            check($sformatf("R3-R8 table row %0d", i), v, VEC[i][15:0]);
        end
        // mask now 0x0003, status 0

        // R2 raw readback and ignored write
        @(negedge clk);
        raw = 16'h1234;
        rd(2'd0, v); check("R2 raw read", v, 16'h1234);
        step(16'h0000, 1'b1, 2'd0, 16'hFFFF);
        rd(2'd2, v); check("R2 mask after raw write", v, 16'h0003);
        rd(2'd1, v); check("R2 status after raw write", v, 16'h0000);

        // R10 alert timing
        step(16'h0001, 1'b0, 2'd1, 16'h0000);
        raw = 16'h0000;
        check("R10 alert not yet high", {15'd0, alert}, 16'h0000);
        @(posedge clk); #0.5;
        check("R10 alert high", {15'd0, alert}, 16'h0001);
        step(16'h0000, 1'b1, 2'd1, 16'h0001);
        check("R10 alert still high", {15'd0, alert}, 16'h0001);
        @(posedge clk); #0.5;
        check("R10 alert low", {15'd0, alert}, 16'h0000);

        // R9 default mask locking and reload on exit
        step(16'h0000, 1'b1, 2'd3, 16'h1111);
        rd(2'd3, v); check("R9 default locked", v, 16'hF882);
        @(negedge clk); cfg_mode = 1'b1;
        step(16'h0000, 1'b1, 2'd3, 16'h00F0);
        rd(2'd3, v); check("R9 default written", v, 16'h00F0);
        rd(2'd2, v); check("R9 mask kept in cfg", v, 16'h0003);
        @(negedge clk);
        cfg_mode = 1'b0; wr_en = 1'b1; addr = 2'd2; wdata = 16'h5555;
        @(posedge clk); #0.5;
        rd(2'd2, v); check("R9 reload beats write", v, 16'h00F0);
        step(16'h00F0, 1'b0, 2'd1, 16'h0000);
        rd(2'd1, v); check("R9 reloaded mask captures", v, 16'h00F0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule